// File: doc/BRIEF.md
# Link-Init Configuration Request Handshake

This block lives on the link controller side of a memory link. After reset it waits until the attached memory device has been ready for a fixed power-up interval of 20 ms. It then asks an external configuration master to program the device registers. The request and the master's "loaded" acknowledge follow a four-phase handshake: the request rises, the acknowledge rises, the request falls, and the acknowledge falls. When the acknowledge has returned low, the block emits a one-cycle done pulse that lets link training go ahead.

The power-up interval is counted in clock cycles. The terminal count is W = (CLK_FREQ_HZ / 1000) * INIT_MS. A simulation strap skips the interval entirely.

The block runs the handshake once per reset. Later activity on its inputs has no effect until the next reset. An acknowledge that arrives while no request is outstanding is treated as stale: the block flags it and does not raise a request while it persists.

The asynchronous active-low reset is released through a two-stage synchronizer. The logic therefore acts on inputs from the third rising edge after `rst_n` rises.

Top module: `cfgl_link_init_req`

## Requirements
- R1: While `rst_n` is low, `load_req_o`, `init_done_o` and `proto_err_o` are low, and asserting `rst_n` clears an outstanding request at once, without waiting for a clock edge.
- R2: With the strap low, `load_req_o` rises on the clock edge that follows W consecutive edges at which `dev_ready_i` was sampled high, and not earlier.
- R3: An edge at which `dev_ready_i` is sampled low restarts the power-up count, so a fresh run of W high samples is needed.
- R4: With `sim_bypass_i` sampled high, `load_req_o` rises on that same edge, regardless of `dev_ready_i`.
- R5: Once raised, `load_req_o` stays high for as long as `loaded_ack_i` stays low.
- R6: `load_req_o` falls on the first edge at which `loaded_ack_i` is sampled high while the request is outstanding.
- R7: After the request has fallen, `init_done_o` is high for exactly one cycle. It rises on the first edge at which `loaded_ack_i` is sampled low, and not before.
- R8: After the done pulse, `load_req_o` and `init_done_o` stay low whatever the inputs do, until the next reset.
- R9: While no request has yet been raised, each edge that samples `loaded_ack_i` high sets `proto_err_o` high for the following cycle and holds the request off, even if the wait has expired. The request then rises on the first edge at which the acknowledge is sampled low and the device is still ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dev_ready_i | input | 1 | Device power/ready indication, synchronous to `clk` |
| sim_bypass_i | input | 1 | Strap that skips the power-up wait |
| loaded_ack_i | input | 1 | Acknowledge from the configuration master: registers loaded |
| load_req_o | output | 1 | Request to the configuration master to program the device |
| init_done_o | output | 1 | One-cycle pulse: handshake complete, link training may proceed |
| proto_err_o | output | 1 | Stale acknowledge seen while no request was outstanding |

## Verification
The expiry of the power-up count and the detection of a stale acknowledge can land on the same clock edge. At that edge, both "raise the request" and "flag an error" are candidate actions. The bench provokes this by holding the acknowledge high from before the device becomes ready until several cycles after the count has run out. It judges the outcome by three observations: `proto_err_o` is high after every such edge, `load_req_o` stays low throughout, and the request rises exactly one edge after the acknowledge is dropped.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  // Handshake progress, one state per phase plus a terminal state.
  typedef enum logic [1:0] {
    ST_WAIT_RDY = 2'd0,
    ST_REQ      = 2'd1,
    ST_ACK_LOW  = 2'd2,
    ST_DONE     = 2'd3
  } hs_state_e;

endpackage

// File: rtl/cfgl_rst_sync.sv
module cfgl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/cfgl_init_timer.sv
module cfgl_init_timer #(
  parameter int WAIT_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_ready_i,
  output logic expired_o
);

  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(WAIT_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Count consecutive ready cycles; saturate at the terminal count.
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!dev_ready_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q != TERM) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (cnt_q == TERM);

endmodule

// File: rtl/cfgl_hs_fsm.sv
module cfgl_hs_fsm
  import cfgl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ready_i,
  input  logic ack_i,
  output logic req_o,
  output logic done_o,
  output logic err_o
);

  hs_state_e state_q, state_d;
  logic      req_q, req_d;
  logic      done_q, done_d;
  logic      err_q, err_d;

  always_comb begin
    state_d = state_q;
    req_d   = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_WAIT_RDY: begin
        if (ack_i) begin
          err_d = 1'b1;          // stale acknowledge: hold off
        end else if (ready_i) begin
          state_d = ST_REQ;
          req_d   = 1'b1;
        end
      end
      ST_REQ: begin
        if (ack_i) begin
          state_d = ST_ACK_LOW;
        end else begin
          req_d = 1'b1;
        end
      end
      ST_ACK_LOW: begin
        if (!ack_i) begin
          state_d = ST_DONE;
          done_d  = 1'b1;
        end
      end
      ST_DONE: begin
        state_d = ST_DONE;
      end
      default: begin
        state_d = ST_WAIT_RDY;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT_RDY;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign req_o  = req_q;
  assign done_o = done_q;
  assign err_o  = err_q;

endmodule

// File: rtl/cfgl_link_init_req.sv
module cfgl_link_init_req #(
  parameter int CLK_FREQ_HZ = 200_000_000,
  parameter int INIT_MS     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_ready_i,
  input  logic sim_bypass_i,
  input  logic loaded_ack_i,
  output logic load_req_o,
  output logic init_done_o,
  output logic proto_err_o
);

  localparam int CYC_PER_MS  = CLK_FREQ_HZ / 1000;
  localparam int WAIT_CYCLES = CYC_PER_MS * INIT_MS;

  logic rst_int_n;
  logic wait_expired;
  logic ready_ok;

  cfgl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  cfgl_init_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .dev_ready_i (dev_ready_i),
    .expired_o   (wait_expired)
  );

  assign ready_ok = sim_bypass_i | wait_expired;

  cfgl_hs_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ready_i (ready_ok),
    .ack_i   (loaded_ack_i),
    .req_o   (load_req_o),
    .done_o  (init_done_o),
    .err_o   (proto_err_o)
  );

endmodule

// File: rtl/cfgl_link_init_req_chk.sv
module cfgl_link_init_req_chk #(
  parameter int CLK_FREQ_HZ = 200_000_000,
  parameter int INIT_MS     = 20
) (
  input logic clk,
  input logic rst_n,
  input logic dev_ready_i,
  input logic sim_bypass_i,
  input logic loaded_ack_i,
  input logic load_req_o,
  input logic init_done_o,
  input logic proto_err_o
);

  localparam int W = (CLK_FREQ_HZ / 1000) * INIT_MS;

  int   rdy_run;
  logic done_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_run   <= 0;
      done_seen <= 1'b0;
    end else begin
      if (!dev_ready_i)  rdy_run <= 0;
      else if (rdy_run < W) rdy_run <= rdy_run + 1;
      done_seen <= done_seen | init_done_o;
    end
  end

  // R2 / R4: a new request needs the full wait or the strap
  p_req_after_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_req_o) |-> ($past(sim_bypass_i) || $past(rdy_run) >= W));

  // R6: acknowledge withdraws the request on the next edge
  p_req_drop_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req_o && loaded_ack_i) |=> !load_req_o);

  // R7: done is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |=> !init_done_o);

  // R7: done only after the acknowledge was seen low
  p_done_after_ack_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done_o) |-> $past(!loaded_ack_i));

  // R8: nothing more once done has been issued
  p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_seen |-> (!load_req_o && !init_done_o));

  // R9: an error flag never coincides with an outstanding request
  p_err_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |-> !load_req_o);

endmodule

bind cfgl_link_init_req cfgl_link_init_req_chk #(
  .CLK_FREQ_HZ (CLK_FREQ_HZ),
  .INIT_MS     (INIT_MS)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dev_ready_i  (dev_ready_i),
  .sim_bypass_i (sim_bypass_i),
  .loaded_ack_i (loaded_ack_i),
  .load_req_o   (load_req_o),
  .init_done_o  (init_done_o),
  .proto_err_o  (proto_err_o)
);

// File: tb/test_cfgl_link_init_req.sv
module test_cfgl_link_init_req;

  localparam int CLK_PERIOD = 10;
  localparam int FREQ_HZ    = 1000;
  localparam int WAIT_MS    = 20;
  localparam int W          = (FREQ_HZ / 1000) * WAIT_MS;

  logic clk;
  logic rst_n;
  logic dev_ready;
  logic sim_bypass;
  logic loaded_ack;
  logic load_req;
  logic init_done;
  logic proto_err;

  int checks;
  int errors;

  cfgl_link_init_req #(
    .CLK_FREQ_HZ (FREQ_HZ),
    .INIT_MS     (WAIT_MS)
  ) i_cfgl_link_init_req (
    .clk          (clk),
    .rst_n        (rst_n),
    .dev_ready_i  (dev_ready),
    .sim_bypass_i (sim_bypass),
    .loaded_ack_i (loaded_ack),
    .load_req_o   (load_req),
    .init_done_o  (init_done),
    .proto_err_o  (proto_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Advance one rising edge and settle at the following falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n      = 1'b0;
    dev_ready  = 1'b0;
    sim_bypass = 1'b0;
    loaded_ack = 1'b0;
    repeat (3) step();
    check("R1 req in reset", load_req, 1'b0);
    check("R1 done in reset", init_done, 1'b0);
    check("R1 err in reset", proto_err, 1'b0);
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  // R2, R5, R6, R7, R8: full handshake after the timed wait
  task automatic t_full_handshake();
    do_reset();
    dev_ready = 1'b1;
    for (int i = 0; i < W; i++) begin
      step();
      if (load_req !== 1'b0) check("R2 req before wait", load_req, 1'b0);
    end
    checks++;
    step();
    check("R2 req after wait", load_req, 1'b1);
    repeat (25) step();
    check("R5 req held", load_req, 1'b1);
    loaded_ack = 1'b1;
    step();
    check("R6 req dropped", load_req, 1'b0);
    check("R7 no early done", init_done, 1'b0);
    repeat (4) step();
    check("R7 done waits for ack low", init_done, 1'b0);
    loaded_ack = 1'b0;
    step();
    check("R7 done pulse", init_done, 1'b1);
    step();
    check("R7 done one cycle", init_done, 1'b0);
    for (int i = 0; i < 30; i++) begin
      dev_ready  = i[0];
      sim_bypass = i[1];
      loaded_ack = i[2];
      step();
      if (load_req !== 1'b0 || init_done !== 1'b0) begin
        check("R8 quiet after done", load_req | init_done, 1'b0);
      end
    end
    checks++;
    check("R8 req stays low", load_req, 1'b0);
  endtask

  // R3: a dropout of the ready signal restarts the count
  task automatic t_ready_dropout();
    do_reset();
    dev_ready = 1'b1;
    repeat (W - 1) step();
    dev_ready = 1'b0;
    step();
    dev_ready = 1'b1;
    repeat (W) step();
    check("R3 no req before restarted count", load_req, 1'b0);
    step();
    check("R3 req after restarted count", load_req, 1'b1);
  endtask

  // R4: the strap skips the wait
  task automatic t_bypass();
    do_reset();
    sim_bypass = 1'b1;
    step();
    check("R4 req with strap", load_req, 1'b1);
  endtask

  // R1: reset clears an outstanding request asynchronously
  task automatic t_async_reset();
    do_reset();
    sim_bypass = 1'b1;
    step();
    check("R1 req up before reset", load_req, 1'b1);
    #1 rst_n = 1'b0;
    #1;
    check("R1 async clear", load_req, 1'b0);
    step();
    rst_n = 1'b1;
  endtask

  // R9: stale acknowledge collides with wait expiry
  task automatic t_stale_ack();
    do_reset();
    loaded_ack = 1'b1;
    dev_ready  = 1'b1;
    for (int i = 0; i < W + 3; i++) begin
      step();
      if (proto_err !== 1'b1) check("R9 err flagged", proto_err, 1'b1);
      if (load_req !== 1'b0)  check("R9 req held off", load_req, 1'b0);
    end
    checks++;
    check("R9 err at expiry", proto_err, 1'b1);
    loaded_ack = 1'b0;
    step();
    check("R9 req after ack low", load_req, 1'b1);
    check("R9 err cleared", proto_err, 1'b0);
  endtask

  initial begin
    checks     = 0;
    errors     = 0;
    rst_n      = 1'b0;
    dev_ready  = 1'b0;
    sim_bypass = 1'b0;
    loaded_ack = 1'b0;
    t_full_handshake();
    t_ready_dropout();
    t_bypass();
    t_async_reset();
    t_stale_ack();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule